// File: doc/BRIEF.md
# Command-Mode Panel Sequencer

This block runs a stream of 12-bit command words against a display panel that keeps its own frame memory. The panel is reached over an 8-bit parallel bus with a register/data select line (A0), an active-low chip select, and active-low write and read strobes. Each word either performs one bus cycle or performs a sequencing step. The bus-cycle kinds are a command write, a data write, a status read and a frame-memory read. The sequencing steps are a wait for vertical sync, a millisecond delay, a command interrupt and a no-op.

Words arrive on a ready/valid port. A frame-write word streams a run of pixel bytes from a second ready/valid port. The run length comes from a separate input. After every read the sequencer stops, and it resumes only once software sets a continue bit. Read results and two sticky interrupt flags appear on output ports. Each flag has its own mask. One registered interrupt line combines the two.

Top module: `panel_cmd_seq`

## Requirements
- R1: A command word carries the opcode in bits 11:9, the A0 level in bit 8 and the payload in bits 7:0. Out of reset `cmd_ready` is high, chip select and both strobes are high, and `irq` and `rd_status` are zero.
- R2: Opcode 1 performs one bus write. It drives A0 from bit 8 and places the payload on `panel_dout`.
- R3: During every bus cycle `panel_cs_n` stays low while a strobe is low. The strobe stays low for exactly `strobe_clks` clocks, and a value of 0 counts as 1. Only one strobe is low at a time. `panel_doe` is high only during writes.
- R4: Opcode 0 performs one bus read. `panel_din` is captured when `panel_rd_n` rises. The captured byte goes to `rd_status[7:0]` and the A0 level to `rd_status[8]`. The ok flag `rd_status[9]` is set and `rd_irq_flag` is set.
- R5: After a read the sequencer holds `cmd_ready` low until `cont_set` has set the continue bit `rd_status[10]`. It then clears that bit and accepts the next word.
- R6: Opcode 2 with A0 high writes `frame_len` pixel bytes from the pixel port. Each byte is a data write with A0 high. A length of 0 produces no bus cycle. Opcode 2 with A0 low acts as a no-op.
- R7: Opcode 3 holds `cmd_ready` low until a rising edge of `vsync` occurs after the word has been accepted.
- R8: Opcodes 4 and 7 produce no bus cycle, and the next word is accepted on the following clock.
- R9: Opcode 5 sets `cmd_irq_flag`. On each clock `irq` is registered from (`rd_irq_flag` and not `rd_irq_mask`) or (`cmd_irq_flag` and not `cmd_irq_mask`). `rd_irq_clr` and `cmd_irq_clr` clear their flags.
- R10: Opcode 6 completes on the N-th `tick_1ms` pulse after acceptance, where N is the payload (0 to 255). A payload of 0 completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_clks | input | 4 | Strobe low time in clocks (0 means 1) |
| cmd_valid | input | 1 | Command word valid |
| cmd_word | input | 12 | Command word |
| cmd_ready | output | 1 | Sequencer accepts a word |
| frame_len | input | 16 | Pixel byte count for frame writes |
| pix_valid | input | 1 | Pixel byte valid |
| pix_data | input | 8 | Pixel byte |
| pix_ready | output | 1 | Sequencer accepts a pixel byte |
| vsync | input | 1 | Vertical sync from panel |
| tick_1ms | input | 1 | One-clock pulse every millisecond |
| cont_set | input | 1 | Sets the continue bit |
| rd_irq_clr | input | 1 | Clears the read interrupt flag |
| cmd_irq_clr | input | 1 | Clears the command interrupt flag |
| rd_irq_mask | input | 1 | Masks the read interrupt when high |
| cmd_irq_mask | input | 1 | Masks the command interrupt when high |
| rd_status | output | 11 | {continue, ok, A0, data} of the last read |
| rd_irq_flag | output | 1 | Read-complete flag |
| cmd_irq_flag | output | 1 | Command interrupt flag |
| irq | output | 1 | Combined, masked interrupt |
| panel_cs_n | output | 1 | Chip select, active low |
| panel_a0 | output | 1 | Register/data select |
| panel_wr_n | output | 1 | Write strobe, active low |
| panel_rd_n | output | 1 | Read strobe, active low |
| panel_dout | output | 8 | Bus data driven by the sequencer |
| panel_doe | output | 1 | Output enable for panel_dout |
| panel_din | input | 8 | Bus data from the panel |

## Verification
The first group of words mixes command writes and data writes at strobe widths of 3, 0 and 2. This shows whether A0 follows bit 8 and whether the zero width is raised to one clock. Reads are made with A0 low and with A0 high, and the bench checks that the sequencer stays stalled until the continue pulse arrives. Frame writes are run with a length of 3 and with a length of 0. These runs separate the per-byte data cycles from the empty case. No-op, vsync, delay and interrupt words are checked for the absence of bus events and for the exact clock on which the next word is accepted.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int WORD_W = 12;
  localparam int PAY_W  = 8;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_FRAME = 3'd2,
    OP_VSYNC = 3'd3,
    OP_NOP   = 3'd4,
    OP_IRQ   = 3'd5,
    OP_DELAY = 3'd6,
    OP_SPARE = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_FETCH, S_BUS, S_RDSTALL, S_PIX, S_PIXBUS, S_VSYNC, S_DELAY
  } seq_st_e;

  function automatic op_e word_op(input logic [WORD_W-1:0] w);
    return op_e'(w[11:9]);
  endfunction
endpackage

// File: rtl/psq_bus_cycle.sv
module psq_bus_cycle #(
  parameter int DW    = 8,
  parameter int STB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_read,
  input  logic             a0_in,
  input  logic [DW-1:0]    wdata,
  input  logic [STB_W-1:0] width,
  input  logic [DW-1:0]    din,
  output logic             cs_n,
  output logic             a0,
  output logic             wr_n,
  output logic             rd_n,
  output logic [DW-1:0]    dout,
  output logic             doe,
  output logic [DW-1:0]    rdata,
  output logic             done
);
  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_STROBE, B_HOLD} bst_e;
  bst_e st;
  logic [STB_W-1:0] cnt;
  logic             rd_mode;
  logic [STB_W-1:0] width_eff;

  assign width_eff = (width == '0) ? STB_W'(1) : width;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_IDLE; cnt <= '0; rd_mode <= 1'b0;
      cs_n <= 1'b1; a0 <= 1'b0; wr_n <= 1'b1; rd_n <= 1'b1;
      dout <= '0; doe <= 1'b0; rdata <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          st <= B_SETUP; cs_n <= 1'b0; a0 <= a0_in;
          rd_mode <= is_read; dout <= wdata; doe <= !is_read;
        end
        B_SETUP: begin
          st  <= B_STROBE;
          cnt <= width_eff - STB_W'(1);
          if (rd_mode) rd_n <= 1'b0;
          else         wr_n <= 1'b0;
        end
        B_STROBE: begin
          if (cnt == '0) begin
            st <= B_HOLD; wr_n <= 1'b1; rd_n <= 1'b1;
            if (rd_mode) rdata <= din;
          end else begin
            cnt <= cnt - STB_W'(1);
          end
        end
        default: begin
          st <= B_IDLE; cs_n <= 1'b1; doe <= 1'b0; done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/psq_ms_timer.sv
module psq_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (tick && cnt != '0)  cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq
  import psq_pkg::*;
#(
  parameter int STB_W = 4,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STB_W-1:0] strobe_clks,
  input  logic             cmd_valid,
  input  logic [11:0]      cmd_word,
  output logic             cmd_ready,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             pix_valid,
  input  logic [7:0]       pix_data,
  output logic             pix_ready,
  input  logic             vsync,
  input  logic             tick_1ms,
  input  logic             cont_set,
  input  logic             rd_irq_clr,
  input  logic             cmd_irq_clr,
  input  logic             rd_irq_mask,
  input  logic             cmd_irq_mask,
  output logic [10:0]      rd_status,
  output logic             rd_irq_flag,
  output logic             cmd_irq_flag,
  output logic             irq,
  output logic             panel_cs_n,
  output logic             panel_a0,
  output logic             panel_wr_n,
  output logic             panel_rd_n,
  output logic [7:0]       panel_dout,
  output logic             panel_doe,
  input  logic [7:0]       panel_din
);
  seq_st_e          st;
  op_e              op;
  logic [PAY_W-1:0] pay;
  logic             wa0;
  logic             go, go_rd, go_a0;
  logic [PAY_W-1:0] go_data;
  logic [PAY_W-1:0] bus_rdata;
  logic             bus_done;
  logic [LEN_W-1:0] remain;
  logic             vs_q;
  logic             cont, ok, rd_a0;
  logic [PAY_W-1:0] rd_data;
  logic             tmr_load, tmr_expire;

  assign op        = word_op(cmd_word);
  assign pay       = cmd_word[PAY_W-1:0];
  assign wa0       = cmd_word[8];
  assign cmd_ready = (st == S_FETCH);
  assign pix_ready = (st == S_PIX);
  assign rd_status = {cont, ok, rd_a0, rd_data};
  assign tmr_load  = cmd_ready && cmd_valid && (op == OP_DELAY);

  psq_bus_cycle #(.DW(PAY_W), .STB_W(STB_W)) u_bus (
    .clk(clk), .rst(rst), .start(go), .is_read(go_rd), .a0_in(go_a0),
    .wdata(go_data), .width(strobe_clks), .din(panel_din),
    .cs_n(panel_cs_n), .a0(panel_a0), .wr_n(panel_wr_n), .rd_n(panel_rd_n),
    .dout(panel_dout), .doe(panel_doe), .rdata(bus_rdata), .done(bus_done)
  );

  psq_ms_timer #(.CNT_W(PAY_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(pay),
    .tick(tick_1ms), .expire(tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH; go <= 1'b0; go_rd <= 1'b0; go_a0 <= 1'b0; go_data <= '0;
      remain <= '0; vs_q <= 1'b0; cont <= 1'b0; ok <= 1'b0; rd_a0 <= 1'b0;
      rd_data <= '0; rd_irq_flag <= 1'b0; cmd_irq_flag <= 1'b0; irq <= 1'b0;
    end else begin
      go   <= 1'b0;
      vs_q <= vsync;
      irq  <= (rd_irq_flag && !rd_irq_mask) || (cmd_irq_flag && !cmd_irq_mask);
      if (cont_set)    cont         <= 1'b1;
      if (rd_irq_clr)  rd_irq_flag  <= 1'b0;
      if (cmd_irq_clr) cmd_irq_flag <= 1'b0;
      case (st)
        S_FETCH: if (cmd_valid) begin
          case (op)
            OP_READ: begin
              go <= 1'b1; go_rd <= 1'b1; go_a0 <= wa0; ok <= 1'b0; st <= S_BUS;
            end
            OP_WRITE: begin
              go <= 1'b1; go_rd <= 1'b0; go_a0 <= wa0; go_data <= pay; st <= S_BUS;
            end
            OP_FRAME: if (wa0 && frame_len != '0) begin
              remain <= frame_len; st <= S_PIX;
            end
            OP_VSYNC: st <= S_VSYNC;
            OP_IRQ:   cmd_irq_flag <= 1'b1;
            OP_DELAY: if (pay != '0) st <= S_DELAY;
            default: ;
          endcase
        end
        S_BUS: if (bus_done) begin
          if (go_rd) begin
            rd_data <= bus_rdata; rd_a0 <= go_a0; ok <= 1'b1;
            rd_irq_flag <= 1'b1; st <= S_RDSTALL;
          end else begin
            st <= S_FETCH;
          end
        end
        S_RDSTALL: if (cont) begin
          cont <= 1'b0; st <= S_FETCH;
        end
        S_PIX: if (pix_valid) begin
          go <= 1'b1; go_rd <= 1'b0; go_a0 <= 1'b1; go_data <= pix_data;
          st <= S_PIXBUS;
        end
        S_PIXBUS: if (bus_done) begin
          if (remain == LEN_W'(1)) st <= S_FETCH;
          else begin
            remain <= remain - LEN_W'(1); st <= S_PIX;
          end
        end
        S_VSYNC: if (vsync && !vs_q) st <= S_FETCH;
        S_DELAY: if (tmr_expire) st <= S_FETCH;
        default: st <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/psq_seq_chk.sv
module psq_seq_chk (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic pix_ready,
  input logic panel_cs_n,
  input logic panel_wr_n,
  input logic panel_rd_n,
  input logic panel_doe,
  input logic rd_irq_flag,
  input logic cmd_irq_flag,
  input logic rd_irq_mask,
  input logic cmd_irq_mask,
  input logic irq
);
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (rst)
    (!panel_wr_n || !panel_rd_n) |-> !panel_cs_n);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(!panel_wr_n && !panel_rd_n));
  p_oe_write_only_r3: assert property (@(posedge clk) disable iff (rst)
    panel_doe |-> (!panel_cs_n && panel_rd_n));
  p_ready_bus_idle_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> panel_cs_n);
  p_pix_bus_idle_r6: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> panel_cs_n);
  p_irq_masking_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == (($past(rd_irq_flag) && !$past(rd_irq_mask)) ||
                            ($past(cmd_irq_flag) && !$past(cmd_irq_mask))));
endmodule

bind panel_cmd_seq psq_seq_chk u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .pix_ready(pix_ready),
  .panel_cs_n(panel_cs_n), .panel_wr_n(panel_wr_n), .panel_rd_n(panel_rd_n),
  .panel_doe(panel_doe), .rd_irq_flag(rd_irq_flag), .cmd_irq_flag(cmd_irq_flag),
  .rd_irq_mask(rd_irq_mask), .cmd_irq_mask(cmd_irq_mask), .irq(irq)
);

// File: tb/tb_panel_cmd_seq.sv
`timescale 1ns/1ps
module tb_panel_cmd_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] strobe_clks = 4'd3;
  logic cmd_valid = 1'b0;
  logic [11:0] cmd_word = '0;
  logic cmd_ready;
  logic [15:0] frame_len = '0;
  logic pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic pix_ready;
  logic vsync = 1'b0, tick_1ms = 1'b0, cont_set = 1'b0;
  logic rd_irq_clr = 1'b0, cmd_irq_clr = 1'b0, rd_irq_mask = 1'b0, cmd_irq_mask = 1'b0;
  logic [10:0] rd_status;
  logic rd_irq_flag, cmd_irq_flag, irq;
  logic panel_cs_n, panel_a0, panel_wr_n, panel_rd_n, panel_doe;
  logic [7:0] panel_dout;
  logic [7:0] panel_din = '0;

  int total = 0;
  int bad = 0;
  int ev_cnt = 0;
  bit finished = 1'b0;
  logic [9:0] exp_q[$];

  always #4 clk = ~clk;

  panel_cmd_seq dut (.*);

  task automatic check(input bit cond, input string req, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: strobe width and bus events, sampled at negedge
  logic pw = 1'b1, pr = 1'b1;
  int lowcnt = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (!panel_wr_n || !panel_rd_n) lowcnt++;
      if ((!pw && panel_wr_n) || (!pr && panel_rd_n)) begin
        logic [9:0] got;
        int wexp;
        got = (!pr) ? {1'b1, panel_a0, panel_din} : {1'b0, panel_a0, panel_dout};
        wexp = (strobe_clks == 0) ? 1 : int'(strobe_clks);
        ev_cnt++;
        check(lowcnt == wexp, "R3 strobe width", lowcnt, wexp);
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected bus cycle", int'(got), 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check(got == e, "R2/R4/R6 bus event", int'(got), int'(e));
        end
        lowcnt = 0;
      end
      pw = panel_wr_n; pr = panel_rd_n;
    end
  end

  task automatic send(input logic [11:0] w);
    cmd_word = w; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send_pix(input logic [7:0] b);
    pix_data = b; pix_valid = 1'b1;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(cmd_ready && panel_cs_n));
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ev0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready && panel_cs_n && panel_wr_n && panel_rd_n, "R1 reset bus idle", 0, 1);
    check(irq == 0 && rd_status == 0, "R1 reset status", int'(rd_status), 0);

    // R2/R3 writes at widths 3, 0, 2
    exp_q.push_back({1'b0, 1'b0, 8'h2C}); send(12'h22C); wait_idle();
    exp_q.push_back({1'b0, 1'b1, 8'h11}); send(12'h311); wait_idle();
    strobe_clks = 4'd0;
    exp_q.push_back({1'b0, 1'b1, 8'h7E}); send(12'h37E); wait_idle();
    strobe_clks = 4'd2;
    exp_q.push_back({1'b0, 1'b0, 8'hC3}); send(12'h2C3); wait_idle();

    // R4/R5 status read, stall until continue
    panel_din = 8'hA5;
    exp_q.push_back({1'b1, 1'b0, 8'hA5}); send(12'h000);
    repeat (20) @(negedge clk);
    check(!cmd_ready, "R5 stalled after read", int'(cmd_ready), 0);
    check(rd_status == {1'b0, 1'b1, 1'b0, 8'hA5}, "R4 status read", int'(rd_status), 11'h2A5);
    check(rd_irq_flag && irq, "R4 read flag and irq (R9)", int'({rd_irq_flag, irq}), 3);
    pulse(cont_set);
    @(negedge clk);
    check(cmd_ready && !rd_status[10], "R5 continue consumed", int'({cmd_ready, rd_status[10]}), 2);

    // R4 frame memory read, A0 high
    panel_din = 8'h3C;
    exp_q.push_back({1'b1, 1'b1, 8'h3C}); send(12'h100);
    repeat (15) @(negedge clk);
    check(rd_status[9:0] == {1'b1, 1'b1, 8'h3C}, "R4 frame read", int'(rd_status), 11'h33C);
    pulse(cont_set); @(negedge clk);
    check(cmd_ready, "R5 resumes", int'(cmd_ready), 1);
    pulse(rd_irq_clr); @(negedge clk);
    check(!rd_irq_flag && !irq, "R9 read flag cleared", int'({rd_irq_flag, irq}), 0);

    // R6 frame write of 3 bytes
    frame_len = 16'd3;
    send(12'h500);
    foreach (exp_q[i]) ;
    for (int k = 0; k < 3; k++) begin
      exp_q.push_back({1'b0, 1'b1, 8'h40 + 8'(k)});
      send_pix(8'h40 + 8'(k));
    end
    wait_idle();
    check(exp_q.size() == 0, "R6 all pixels written", exp_q.size(), 0);

    // R6 length 0, R6/R8 no-ops
    ev0 = ev_cnt;
    frame_len = 16'd0;
    send(12'h500);
    check(cmd_ready, "R6 zero length completes", int'(cmd_ready), 1);
    send(12'h400);
    check(cmd_ready, "R6 opcode 2 A0 low is no-op", int'(cmd_ready), 1);
    send(12'h800);
    check(cmd_ready, "R8 opcode 4 no-op", int'(cmd_ready), 1);
    send(12'hE55);
    check(cmd_ready, "R8 opcode 7 no-op", int'(cmd_ready), 1);
    repeat (10) @(negedge clk);
    check(ev_cnt == ev0, "R8 no bus events", ev_cnt, ev0);

    // R7 vsync wait (level already high does not count)
    vsync = 1'b1; @(negedge clk);
    send(12'h600);
    repeat (10) @(negedge clk);
    check(!cmd_ready, "R7 waits for vsync edge", int'(cmd_ready), 0);
    vsync = 1'b0; repeat (3) @(negedge clk);
    check(!cmd_ready, "R7 falling edge ignored", int'(cmd_ready), 0);
    vsync = 1'b1; @(negedge clk);
    check(cmd_ready, "R7 released by vsync rise", int'(cmd_ready), 1);

    // R9 command interrupt and mask
    send(12'hA00);
    check(cmd_irq_flag, "R9 cmd flag set", int'(cmd_irq_flag), 1);
    @(negedge clk);
    check(irq, "R9 irq raised", int'(irq), 1);
    cmd_irq_mask = 1'b1; repeat (2) @(negedge clk);
    check(!irq && cmd_irq_flag, "R9 masked irq", int'({cmd_irq_flag, irq}), 2);
    cmd_irq_mask = 1'b0;
    pulse(cmd_irq_clr); @(negedge clk);
    check(!cmd_irq_flag && !irq, "R9 cmd flag cleared", int'({cmd_irq_flag, irq}), 0);

    // R10 delay of 3 ms and 0 ms
    send(12'hC03);
    pulse(tick_1ms); @(negedge clk);
    pulse(tick_1ms); repeat (5) @(negedge clk);
    check(!cmd_ready, "R10 still waiting after 2 ticks", int'(cmd_ready), 0);
    pulse(tick_1ms);
    check(cmd_ready, "R10 done on third tick", int'(cmd_ready), 1);
    send(12'hC00);
    check(cmd_ready, "R10 zero delay immediate", int'(cmd_ready), 1);

    // final write at width 1
    strobe_clks = 4'd1;
    exp_q.push_back({1'b0, 1'b1, 8'h99}); send(12'h399); wait_idle();
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule